// File: doc/BRIEF.md
# Chained-Chunk Instruction Queue Fetcher

This block drives one instruction queue that lives in memory as a linked list of chunks. Software announces new work by writing a count of 64-bit words to a doorbell register. The block keeps the number of words still waiting, a read pointer into the current chunk and a count of instructions in progress. Whenever the queue is enabled and a whole 64-byte instruction (eight words) is waiting, it sends one fetch request on a request/response memory port. Each good response is handed to the execution side as a one-cycle dispatch pulse. The execution side reports each finished instruction with a completion pulse.

A chunk holds a programmable number of instructions. The 8-byte slot that follows the last instruction holds the address of the next chunk. When the current chunk is used up and more work is waiting, the block reads that slot and continues from the address it finds there, which is 128-byte aligned. The block is configured through a small valid/address/data register port. Reads on that port are combinational.

A counter wrap on a doorbell write is recorded as a sticky overflow event. A failed memory read is recorded as a sticky read-error event.

Top module: `iqf_fetcher`

## Requirements
- R1: After reset, the control, doorbell, base, in-flight and event registers all read 0, the chunk-size register reads 16, and no fetch request is asserted.
- R2: A write to the doorbell register (address 1) adds bits 19:3 of the written value, times 8, to a 20-bit pending-word count, modulo 2^20. Bits 2:0 of the written value are ignored. A read of address 1 returns the pending count.
- R3: If a doorbell write brings the pending count plus the added value to 2^20 or more, event bit 0 (address 5) is set and stays set. Writing a 1 to that bit clears it. Writing 2^20 minus the value read back returns the count to 0.
- R4: A request is raised only when all of these hold: enable (address 0, bit 0) is 1, at least 8 words are pending, no earlier fetch is still open, and, for an instruction fetch, the in-flight count is below 255. A raised request holds its address and kind until it is accepted.
- R5: Each accepted instruction fetch advances the read pointer by 64 bytes and lowers the pending count by 8.
- R6: When the chunk-size number of instructions has been fetched from the current chunk, the next request is a link fetch (kind output 1) at the current read pointer. A good link response loads the read pointer from bits 48:7 of the response data, with bits 6:0 cleared, and restarts the count within the chunk.
- R7: A write to the base register (address 2) sets the read pointer to bits 48:6 of the written value and restarts the chunk count. A read of address 2 returns the next fetch address.
- R8: The in-flight count (address 4) rises by one for each accepted instruction fetch. It falls by one for each completion pulse and for each dropped instruction. Writes to address 4 have no effect.
- R9: An instruction response flagged as an error sets event bit 1 (sticky; writing a 1 clears it). The instruction is dropped: no dispatch pulse is produced.
- R10: A link response flagged as an error sets event bit 1, clears enable and leaves the read pointer unchanged.
- R11: A good instruction response produces exactly one dispatch pulse, in the cycle after the response.
- R12: While enable is 0 no new request is raised, but completion pulses still lower the in-flight count.
- R13: A chunk size (address 3, bits 9:0) of 0 behaves as a chunk of one instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data (combinational; 0 when not reading) |
| fetch_req_valid | output | 1 | Fetch request |
| fetch_req_ready | input | 1 | Memory accepts the request |
| fetch_req_addr | output | 49 | Byte address of the fetch |
| fetch_req_link | output | 1 | 1 = next-chunk pointer fetch, 0 = instruction fetch |
| fetch_rsp_valid | input | 1 | Response for the open fetch |
| fetch_rsp_err | input | 1 | Response carries a read error |
| fetch_rsp_data | input | 64 | Response data (used for link fetches) |
| dispatch_valid | output | 1 | Instruction handed to execution |
| eng_done | input | 1 | One dispatched instruction finished |

## Verification
The bench goes after the chunk boundary in three settings: a normal size, a size of zero, and a link whose data has junk in its low and high bits. A design that miscounts the boundary fetches past the link slot or aligns the new pointer wrongly. The bench also wraps the doorbell counter and then recovers it by a modulo write. A design that drops the carry or masks the low bits the wrong way would leave a nonzero count or no overflow event. Error responses are injected on both fetch kinds. A design that still dispatches a failed instruction, leaks an in-flight count, or keeps running after a bad link would be caught. Finally the in-flight counter is driven to its ceiling of 255 while stalls hold requests open. This catches a counter that wraps, or a request whose address changes while it waits.

// File: rtl/iqf_pkg.sv
`timescale 1ns/1ps
// Shared types for the queue fetcher: register selects and fetch sequencer states.
package iqf_pkg;
    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_RING   = 3'd1,
        RA_BASE   = 3'd2,
        RA_CHUNK  = 3'd3,
        RA_FLIGHT = 3'd4,
        RA_EVENTS = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/iqf_doorbell.sv
`timescale 1ns/1ps
// Pending-word counter.
// Adds doorbell values in whole-instruction granules and removes one granule
// per issued instruction. Records a sticky flag when an add carries out of the
// counter. Assumes a granule is taken only while at least one granule is pending.
module iqf_doorbell #(
    parameter int CNT_W      = 20,
    parameter int GRAN_LOG2  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_val,
    input  logic             take,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             has_inst
);
    localparam int STEP = 1 << GRAN_LOG2;

    logic [CNT_W-1:0] add_masked;
    logic [CNT_W:0]   sum;
    logic             unused_low;

    assign unused_low = ^add_val[GRAN_LOG2-1:0];
    assign add_masked = add_en ? {add_val[CNT_W-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}} : '0;
    assign sum        = {1'b0, count} + {1'b0, add_masked};
    assign has_inst   = (count[CNT_W-1:GRAN_LOG2] != '0);

    // Count update: add the doorbell granules, subtract one issued instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= sum[CNT_W-1:0] - (take ? CNT_W'(STEP) : '0);
    end

    // Sticky overflow: a carry on the add wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf_flag <= 1'b0;
        else if (add_en && sum[CNT_W]) ovf_flag <= 1'b1;
        else if (clr_ovf)            ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/iqf_chunk_walker.sv
`timescale 1ns/1ps
// Read pointer and position within the current chunk.
// The pointer is kept in instruction lines. A link load aligns it to the chunk
// granule. at_link goes high once the chunk-size number of instructions has
// been taken. Assumes LINK_LOG2 >= INST_LOG2.
module iqf_chunk_walker #(
    parameter int ADDR_W    = 49,
    parameter int CHUNK_W   = 10,
    parameter int INST_LOG2 = 6,
    parameter int LINK_LOG2 = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_wr,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic               step,
    input  logic               link_load,
    input  logic [ADDR_W-1:0]  link_val,
    input  logic [CHUNK_W-1:0] chunk_size,
    output logic [ADDR_W-1:0]  ptr,
    output logic               at_link
);
    localparam int LINE_W = ADDR_W - INST_LOG2;
    localparam int GAP    = LINK_LOG2 - INST_LOG2;

    logic [LINE_W-1:0]  line_q;
    logic [LINE_W-1:0]  link_line;
    logic [CHUNK_W-1:0] pos_q;
    logic [CHUNK_W-1:0] eff_size;
    logic               unused_low;

    generate
        if (GAP > 0) begin : g_gap
            assign link_line = {link_val[ADDR_W-1:LINK_LOG2], {GAP{1'b0}}};
        end else begin : g_nogap
            assign link_line = link_val[ADDR_W-1:INST_LOG2];
        end
    endgenerate

    assign unused_low = ^{link_val[LINK_LOG2-1:0], base_val[INST_LOG2-1:0]};
    assign eff_size   = (chunk_size == '0) ? CHUNK_W'(1) : chunk_size;
    assign at_link    = (pos_q >= eff_size);
    assign ptr        = {line_q, {INST_LOG2{1'b0}}};

    // Pointer/position update: link load, then base write, then instruction step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            pos_q  <= '0;
        end else if (link_load) begin
            line_q <= link_line;
            pos_q  <= '0;
        end else if (base_wr) begin
            line_q <= base_val[ADDR_W-1:INST_LOG2];
            pos_q  <= '0;
        end else if (step) begin
            line_q <= line_q + LINE_W'(1);
            pos_q  <= pos_q + CHUNK_W'(1);
        end
    end
endmodule

// File: rtl/iqf_flight.sv
`timescale 1ns/1ps
// In-flight instruction counter.
// One increment and up to two decrements can arrive in the same cycle.
// Assumes the caller never increments at full or decrements below zero.
module iqf_flight #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec_drop,
    input  logic         dec_done,
    output logic [W-1:0] count,
    output logic         full
);
    assign full = &count;

    // Net count update for the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + W'(inc) - W'(dec_drop) - W'(dec_done);
    end
endmodule

// File: rtl/iqf_fetcher.sv
`timescale 1ns/1ps
// Doorbell-driven instruction queue fetcher (top).
// Holds the register port, the enable and the sticky events, and a sequencer
// that keeps at most one memory fetch open at a time. Reads are combinational.
// Assumes software changes base and chunk size only while quiescent.
module iqf_fetcher
    import iqf_pkg::*;
#(
    parameter int ADDR_W      = 49,
    parameter int DATA_W      = 64,
    parameter int CNT_W       = 20,
    parameter int FLIGHT_W    = 8,
    parameter int CHUNK_W     = 10,
    parameter int CHUNK_RESET = 16,
    parameter int INST_LOG2   = 6,
    parameter int LINK_LOG2   = 7,
    parameter int GRAN_LOG2   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fetch_req_valid,
    input  logic              fetch_req_ready,
    output logic [ADDR_W-1:0] fetch_req_addr,
    output logic              fetch_req_link,
    input  logic              fetch_rsp_valid,
    input  logic              fetch_rsp_err,
    input  logic [DATA_W-1:0] fetch_rsp_data,
    output logic              dispatch_valid,
    input  logic              eng_done
);
    fetch_state_e       state;
    logic               link_q;
    logic               en_q;
    logic               rderr_q;
    logic               disp_q;
    logic [CHUNK_W-1:0] chunk_q;
    logic [CNT_W-1:0]   pend_cnt;
    logic               ovf_flag;
    logic               has_inst;
    logic [ADDR_W-1:0]  rd_ptr;
    logic               at_link;
    logic [FLIGHT_W-1:0] flight_cnt;
    logic               flight_full;
    logic [DATA_W-1:0]  rd_val;
    logic               unused_bits;

    logic wr, wr_ctrl, wr_ring, wr_base, wr_chunk, wr_events;
    logic accept, acc_inst, rsp_take, link_ok, link_bad, inst_ok, inst_bad, launch;

    assign unused_bits = ^{reg_wdata[DATA_W-1:ADDR_W], fetch_rsp_data[DATA_W-1:ADDR_W]};

    assign wr        = reg_valid && reg_write;
    assign wr_ctrl   = wr && (reg_addr_e'(reg_addr) == RA_CTRL);
    assign wr_ring   = wr && (reg_addr_e'(reg_addr) == RA_RING);
    assign wr_base   = wr && (reg_addr_e'(reg_addr) == RA_BASE);
    assign wr_chunk  = wr && (reg_addr_e'(reg_addr) == RA_CHUNK);
    assign wr_events = wr && (reg_addr_e'(reg_addr) == RA_EVENTS);

    assign accept   = (state == FS_REQ) && fetch_req_ready;
    assign acc_inst = accept && !link_q;
    assign rsp_take = (state == FS_WAIT) && fetch_rsp_valid;
    assign link_ok  = rsp_take && link_q && !fetch_rsp_err;
    assign link_bad = rsp_take && link_q && fetch_rsp_err;
    assign inst_ok  = rsp_take && !link_q && !fetch_rsp_err;
    assign inst_bad = rsp_take && !link_q && fetch_rsp_err;
    assign launch   = (state == FS_IDLE) && en_q && has_inst && (at_link || !flight_full);

    assign fetch_req_valid = (state == FS_REQ);
    assign fetch_req_addr  = rd_ptr;
    assign fetch_req_link  = link_q;
    assign dispatch_valid  = disp_q;

    iqf_doorbell #(.CNT_W(CNT_W), .GRAN_LOG2(GRAN_LOG2)) u_bell (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (wr_ring),
        .add_val  (reg_wdata[CNT_W-1:0]),
        .take     (acc_inst),
        .clr_ovf  (wr_events && reg_wdata[0]),
        .count    (pend_cnt),
        .ovf_flag (ovf_flag),
        .has_inst (has_inst)
    );

    iqf_chunk_walker #(.ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W),
                       .INST_LOG2(INST_LOG2), .LINK_LOG2(LINK_LOG2)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_wr    (wr_base),
        .base_val   (reg_wdata[ADDR_W-1:0]),
        .step       (acc_inst),
        .link_load  (link_ok),
        .link_val   (fetch_rsp_data[ADDR_W-1:0]),
        .chunk_size (chunk_q),
        .ptr        (rd_ptr),
        .at_link    (at_link)
    );

    iqf_flight #(.W(FLIGHT_W)) u_flight (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (acc_inst),
        .dec_drop (inst_bad),
        .dec_done (eng_done),
        .count    (flight_cnt),
        .full     (flight_full)
    );

    // Fetch sequencer: launch, wait for acceptance, wait for the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FS_IDLE;
            link_q <= 1'b0;
        end else begin
            unique case (state)
                FS_IDLE: if (launch) begin
                    state  <= FS_REQ;
                    link_q <= at_link;
                end
                FS_REQ:  if (fetch_req_ready) state <= FS_WAIT;
                FS_WAIT: if (fetch_rsp_valid) state <= FS_IDLE;
                default: state <= FS_IDLE;
            endcase
        end
    end

    // Enable: a failed link read overrides a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        en_q <= 1'b0;
        else if (link_bad) en_q <= 1'b0;
        else if (wr_ctrl)  en_q <= reg_wdata[0];
    end

    // Sticky read-error event: setting wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rderr_q <= 1'b0;
        else if (link_bad || inst_bad)     rderr_q <= 1'b1;
        else if (wr_events && reg_wdata[1]) rderr_q <= 1'b0;
    end

    // Chunk size configuration and the registered dispatch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chunk_q <= CHUNK_W'(CHUNK_RESET);
            disp_q  <= 1'b0;
        end else begin
            if (wr_chunk) chunk_q <= reg_wdata[CHUNK_W-1:0];
            disp_q <= inst_ok;
        end
    end

    // Register read mux.
    always_comb begin
        rd_val = '0;
        case (reg_addr_e'(reg_addr))
            RA_CTRL:   rd_val[0] = en_q;
            RA_RING:   rd_val[CNT_W-1:0] = pend_cnt;
            RA_BASE:   rd_val[ADDR_W-1:0] = rd_ptr;
            RA_CHUNK:  rd_val[CHUNK_W-1:0] = chunk_q;
            RA_FLIGHT: rd_val[FLIGHT_W-1:0] = flight_cnt;
            RA_EVENTS: rd_val[1:0] = {rderr_q, ovf_flag};
            default:   rd_val = '0;
        endcase
        reg_rdata = (reg_valid && !reg_write) ? rd_val : '0;
    end
endmodule

// File: rtl/iqf_fetcher_chk.sv
`timescale 1ns/1ps
// Protocol and counter checks for the queue fetcher, attached by bind.
module iqf_fetcher_chk
    import iqf_pkg::*;
#(
    parameter int ADDR_W   = 49,
    parameter int CNT_W    = 20,
    parameter int FLIGHT_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_valid,
    input logic                reg_write,
    input logic [2:0]          reg_addr,
    input logic                fetch_req_valid,
    input logic                fetch_req_ready,
    input logic [ADDR_W-1:0]   fetch_req_addr,
    input logic                fetch_req_link,
    input logic                fetch_rsp_valid,
    input logic                fetch_rsp_err,
    input logic                dispatch_valid,
    input logic                eng_done,
    input logic [CNT_W-1:0]    pend_cnt,
    input logic                ovf_flag,
    input logic                en_q,
    input logic                link_q,
    input logic [FLIGHT_W-1:0] flight_cnt,
    input fetch_state_e        state
);
    assert_hold_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_valid && !fetch_req_ready && !(reg_valid && reg_write)
        |=> fetch_req_valid && $stable(fetch_req_addr) && $stable(fetch_req_link));

    assert_flight_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_valid && !fetch_req_link |-> flight_cnt != '1);

    assert_pending_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_valid && fetch_req_ready && !fetch_req_link
        && !(reg_valid && reg_write && reg_addr == 3'd1)
        |=> pend_cnt == $past(pend_cnt) - CNT_W'(8));

    assert_ovf_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(reg_valid && reg_write && reg_addr == 3'd1));

    assert_dispatch_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |-> $past(fetch_rsp_valid && !fetch_rsp_err && state == FS_WAIT));

    assert_link_error_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == FS_WAIT && link_q && fetch_rsp_valid && fetch_rsp_err |=> !en_q);

    assert_flight_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flight_cnt != $past(flight_cnt)
        |-> $past((fetch_req_valid && fetch_req_ready) || eng_done
                  || (fetch_rsp_valid && fetch_rsp_err)));
endmodule

bind iqf_fetcher iqf_fetcher_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_valid       (reg_valid),
    .reg_write       (reg_write),
    .reg_addr        (reg_addr),
    .fetch_req_valid (fetch_req_valid),
    .fetch_req_ready (fetch_req_ready),
    .fetch_req_addr  (fetch_req_addr),
    .fetch_req_link  (fetch_req_link),
    .fetch_rsp_valid (fetch_rsp_valid),
    .fetch_rsp_err   (fetch_rsp_err),
    .dispatch_valid  (dispatch_valid),
    .eng_done        (eng_done),
    .pend_cnt        (pend_cnt),
    .ovf_flag        (ovf_flag),
    .en_q            (en_q),
    .link_q          (link_q),
    .flight_cnt      (flight_cnt),
    .state           (state)
);

// File: tb/iqf_fetcher_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock plus directed register checks.
module iqf_fetcher_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        fetch_req_valid, fetch_req_link;
    logic        fetch_req_ready = 1'b1;
    logic [48:0] fetch_req_addr;
    logic        fetch_rsp_valid = 1'b0, fetch_rsp_err = 1'b0;
    logic [63:0] fetch_rsp_data = '0;
    logic        dispatch_valid;
    logic        eng_done = 1'b0;

    iqf_fetcher uut (.*);

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_pend, m_fl, m_st, m_csz, m_pos;
    bit          m_dovf, m_rderr, m_en, m_link, m_disp;
    logic [48:0] m_ptr;

    function automatic int eff(input int c);
        return (c == 0) ? 1 : c;
    endfunction

    function automatic logic [63:0] m_read(input logic [2:0] a);
        logic [63:0] v = '0;
        case (a)
            3'd0: v = {63'd0, m_en};
            3'd1: v = 64'(m_pend);
            3'd2: v = {15'd0, m_ptr};
            3'd3: v = 64'(m_csz);
            3'd4: v = 64'(m_fl);
            3'd5: v = {62'd0, m_rderr, m_dovf};
            default: v = '0;
        endcase
        return v;
    endfunction

    // responder state
    int rsp_cd = 0, done_owed = 0;
    bit rsp_link = 0, inj_inst_err = 0, inj_link_err = 0, auto_done = 1;
    logic [63:0] link_target = '0;

    always @(posedge clk) begin
        bit wr, acc_i, tk, err, launch;
        int sum, n_pend, n_fl, n_st, n_pos, n_csz;
        bit n_dovf, n_rderr, n_en, n_link, n_disp;
        logic [48:0] n_ptr;
        cyc++;
        if (!rst_n) begin
            m_pend = 0; m_fl = 0; m_st = 0; m_csz = 16; m_pos = 0;
            m_dovf = 0; m_rderr = 0; m_en = 0; m_link = 0; m_disp = 0; m_ptr = '0;
        end else begin
            wr    = reg_valid && reg_write;
            acc_i = (m_st == 1) && fetch_req_ready && !m_link;
            tk    = (m_st == 2) && fetch_rsp_valid;
            err   = fetch_rsp_err;
            sum   = m_pend + ((wr && reg_addr == 3'd1) ? int'(reg_wdata[19:0] & 20'hFFFF8) : 0);
            n_dovf = m_dovf;
            if (wr && reg_addr == 3'd5 && reg_wdata[0]) n_dovf = 0;
            if (sum >= (1 << 20)) n_dovf = 1;
            n_pend = (sum - (acc_i ? 8 : 0)) & 32'hFFFFF;
            n_fl = m_fl + (acc_i ? 1 : 0) - ((tk && !m_link && err) ? 1 : 0) - (eng_done ? 1 : 0);
            launch = (m_st == 0) && m_en && (m_pend >= 8) && ((m_pos >= eff(m_csz)) || (m_fl < 255));
            n_ptr = m_ptr; n_pos = m_pos;
            if (wr && reg_addr == 3'd2) begin n_ptr = {reg_wdata[48:6], 6'd0}; n_pos = 0; end
            else if (acc_i) begin n_ptr = m_ptr + 49'd64; n_pos = m_pos + 1; end
            if (tk && m_link && !err) begin n_ptr = {fetch_rsp_data[48:7], 7'd0}; n_pos = 0; end
            n_en = m_en;
            if (wr && reg_addr == 3'd0) n_en = reg_wdata[0];
            if (tk && m_link && err) n_en = 0;
            n_rderr = m_rderr;
            if (wr && reg_addr == 3'd5 && reg_wdata[1]) n_rderr = 0;
            if (tk && err) n_rderr = 1;
            n_csz = (wr && reg_addr == 3'd3) ? int'(reg_wdata[9:0]) : m_csz;
            n_disp = tk && !m_link && !err;
            n_st = m_st; n_link = m_link;
            if (m_st == 0 && launch) begin n_st = 1; n_link = (m_pos >= eff(m_csz)); end
            else if (m_st == 1 && fetch_req_ready) n_st = 2;
            else if (m_st == 2 && fetch_rsp_valid) n_st = 0;
            m_pend = n_pend; m_fl = n_fl; m_st = n_st; m_csz = n_csz; m_pos = n_pos;
            m_dovf = n_dovf; m_rderr = n_rderr; m_en = n_en; m_link = n_link;
            m_disp = n_disp; m_ptr = n_ptr;
        end
        // memory and engine responder bookkeeping (observes the ports)
        if (fetch_rsp_valid && fetch_rsp_err) begin
            if (rsp_link) inj_link_err = 0; else inj_inst_err = 0;
        end
        if (fetch_req_valid && fetch_req_ready) begin rsp_cd = 2; rsp_link = fetch_req_link; end
        else if (rsp_cd > 0) rsp_cd--;
        if (dispatch_valid) done_owed++;
        if (eng_done) done_owed--;
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(fetch_req_valid == (m_st == 1), "R4 request valid", 64'(fetch_req_valid), 64'(m_st == 1));
            if (m_st == 1) begin
                chk(fetch_req_addr == m_ptr, "R5 fetch address", 64'(fetch_req_addr), 64'(m_ptr));
                chk(fetch_req_link == m_link, "R6 fetch kind", 64'(fetch_req_link), 64'(m_link));
            end
            chk(dispatch_valid == m_disp, "R11 dispatch", 64'(dispatch_valid), 64'(m_disp));
            chk(reg_rdata == ((reg_valid && !reg_write) ? m_read(reg_addr) : 64'd0),
                "R2 register read", reg_rdata, m_read(reg_addr));
        end
    end

    // Drive responder inputs just after the falling edge.
    always @(negedge clk) begin
        #1;
        fetch_req_ready = (cyc % 5) != 3;
        fetch_rsp_valid = (rsp_cd == 1);
        fetch_rsp_err   = (rsp_cd == 1) && (rsp_link ? inj_link_err : inj_inst_err);
        fetch_rsp_data  = rsp_link ? link_target : 64'hDEAD_BEEF_0BAD_F00D;
        eng_done        = auto_done && (done_owed > 0) && (cyc % 3 == 0);
    end

    task automatic reg_wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk); #1;
        reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [63:0] exp, input string tag);
        @(negedge clk); #1;
        reg_valid = 1; reg_write = 0; reg_addr = a;
        @(negedge clk);
        chk(reg_rdata == exp, tag, reg_rdata, exp);
        #1 reg_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd_expect(3'd0, 64'd0, "R1 control after reset");
        rd_expect(3'd1, 64'd0, "R1 doorbell after reset");
        rd_expect(3'd2, 64'd0, "R1 base after reset");
        rd_expect(3'd3, 64'd16, "R1 chunk size after reset");
        rd_expect(3'd4, 64'd0, "R1 in-flight after reset");
        rd_expect(3'd5, 64'd0, "R1 events after reset");
        chk(fetch_req_valid == 0, "R1 no request after reset", 64'(fetch_req_valid), 0);
        // R7 base write, low bits dropped
        reg_wr(3'd2, 64'h0000_0001_2345_67FF);
        rd_expect(3'd2, 64'h0000_0001_2345_67C0, "R7 base readback");
        // R2 doorbell granules; R12 disabled queue does not fetch
        reg_wr(3'd1, 64'd13);
        rd_expect(3'd1, 64'd8, "R2 low bits ignored");
        reg_wr(3'd1, 64'd16);
        idle(20);
        rd_expect(3'd1, 64'd24, "R12 disabled keeps pending");
        chk(fetch_req_valid == 0, "R12 no request while disabled", 64'(fetch_req_valid), 0);
        // R5 three instructions from a chunk of three
        reg_wr(3'd3, 64'd3);
        reg_wr(3'd2, 64'h1000);
        reg_wr(3'd0, 64'd1);
        idle(60);
        rd_expect(3'd2, 64'h10C0, "R5 pointer after three fetches");
        rd_expect(3'd1, 64'd0, "R5 pending drained");
        rd_expect(3'd4, 64'd0, "R8 in-flight back to zero");
        // R6 link with junk in low and high bits
        link_target = 64'hFFFF_0000_0002_00FF;
        reg_wr(3'd1, 64'd16);
        idle(60);
        rd_expect(3'd2, 64'h0001_0000_0002_0100, "R6 pointer after link and two fetches");
        // R9 instruction read error
        inj_inst_err = 1;
        reg_wr(3'd1, 64'd8);
        idle(40);
        rd_expect(3'd5, 64'd2, "R9 read error event");
        rd_expect(3'd4, 64'd0, "R9 dropped instruction leaves flight");
        reg_wr(3'd5, 64'd2);
        rd_expect(3'd5, 64'd0, "R9 event cleared");
        // R10 link read error
        inj_link_err = 1;
        reg_wr(3'd1, 64'd8);
        idle(40);
        rd_expect(3'd0, 64'd0, "R10 enable cleared");
        rd_expect(3'd5, 64'd2, "R10 read error event");
        rd_expect(3'd2, 64'h0001_0000_0002_0140, "R10 pointer unchanged");
        rd_expect(3'd1, 64'd8, "R10 pending kept");
        reg_wr(3'd5, 64'd2);
        link_target = 64'h3000;
        reg_wr(3'd0, 64'd1);
        idle(40);
        rd_expect(3'd2, 64'h3040, "R6 retry of link then fetch");
        // R13 chunk size zero acts as one
        reg_wr(3'd3, 64'd0);
        reg_wr(3'd2, 64'h8000);
        link_target = 64'h9000;
        reg_wr(3'd1, 64'd16);
        idle(60);
        rd_expect(3'd2, 64'h9040, "R13 one instruction per chunk");
        rd_expect(3'd1, 64'd0, "R13 pending drained");
        // R3 overflow and modulo recovery
        reg_wr(3'd0, 64'd0);
        reg_wr(3'd1, 64'hFFFF8);
        rd_expect(3'd1, 64'hFFFF8, "R2 large doorbell");
        reg_wr(3'd1, 64'd16);
        rd_expect(3'd1, 64'd8, "R3 wrapped count");
        rd_expect(3'd5, 64'd1, "R3 overflow event");
        reg_wr(3'd1, 64'hFFFF8);
        rd_expect(3'd1, 64'd0, "R3 recovery to zero");
        reg_wr(3'd5, 64'd1);
        rd_expect(3'd5, 64'd0, "R3 overflow cleared");
        // R4 in-flight ceiling with no completions
        auto_done = 0;
        reg_wr(3'd3, 64'd1023);
        reg_wr(3'd2, 64'h10_0000);
        reg_wr(3'd1, 64'd2048);
        reg_wr(3'd0, 64'd1);
        idle(2500);
        rd_expect(3'd4, 64'd255, "R4 in-flight stops at ceiling");
        rd_expect(3'd1, 64'd8, "R4 one instruction left pending");
        chk(fetch_req_valid == 0, "R4 no request at ceiling", 64'(fetch_req_valid), 0);
        reg_wr(3'd4, 64'd0);
        rd_expect(3'd4, 64'd255, "R8 in-flight is read-only");
        // R12 disable, then let completions drain
        reg_wr(3'd0, 64'd0);
        auto_done = 1;
        idle(1000);
        rd_expect(3'd4, 64'd0, "R12 completions drain while disabled");
        rd_expect(3'd1, 64'd8, "R12 no fetch while disabled");
        rd_expect(3'd2, 64'h10_3FC0, "R5 pointer after 255 fetches");
        idle(5);
        finish_run();
    end
endmodule